// File: doc/BRIEF.md
# Flash Boot Header Loader

This block runs once after every reset. It reads a sixteen-byte header from the highest addresses of a byte-wide parallel flash, moving downward from the top of a 19-bit address space. Along the way it checks three fixed marker bytes. It then loads twelve configuration bytes into output registers that feed a PCI-style configuration space: a device ID, a class code, a subsystem vendor ID, a subsystem ID, and a 32-bit PHY setup word. It drives the flash address, an active-low chip select and an active-low read strobe, and it samples the 8-bit flash data bus at the end of each strobe.

While the header is being read, a retry request stays high so that the bus target answers every access with a retry. One byte in the header selects the strobe length for the reads that follow it, which allows for a fast or a slow flash part. When the sequence ends, a one-cycle done pulse and a loaded flag hand control to the next configuration stage. A bad header leaves every field at its reset default.

Top module: `flash_hdr_loader`

## Requirements
- R1: After `rst_n` rises, the block waits two synchroniser clocks plus START_DLY clocks (default 33) with strobe and select high. The first read strobe goes low in clock START_DLY+2 after the release.
- R2: Read k (k = 0..15) uses address 19'h7FFFF - k, so the last read is at 19'h7FFF0. Consecutive strobe falling edges are BYTE_CLK clocks apart (default 30). The address is stable while the strobe is low.
- R3: The byte at 19'h7FFFF must be 8'hAA and the byte at 19'h7FFFE must be 8'h55. If either differs, no further read is issued, and the block finishes with nothing loaded.
- R4: The byte at 19'h7FFFC must be 8'h55. If it differs, all sixteen reads still take place, but no field is updated and `loaded_o` stays 0.
- R5: The first three reads hold the strobe low for SLOW_CLK clocks (default 12). From the fourth read on, the strobe is low for FAST_CLK clocks (default 6) if the byte at 19'h7FFFD was 8'hAA, and for SLOW_CLK clocks for any other value.
- R6: On a valid header, with b(k) the byte read from 19'h7FFFF - k, the outputs are:
  - dev_id_o = {b5,b4}
  - class_code_o = {b7,b6}
  - subsys_vid_o = {b9,b8}
  - subsys_id_o = {b11,b10}
  - phy_cfg_o = {b15,b14,b13,b12}
- R7: When no valid header has been loaded, the ID and class fields read 0, phy_cfg_o reads 32'h000080F1, and loaded_o reads 0.
- R8: tgt_retry_o is high from reset until the sequence ends. It falls in the same clock as a one-cycle done_o pulse, and it stays low afterwards. That clock is BYTE_CLK clocks after the last strobe fall, or SLOW_CLK clocks after the fall of an aborted read.
- R9: The strobe is low only while the chip select is low, and no read occurs after done_o.
- R10: While rst_n is low, the strobe and select are high, tgt_retry_o is high, done_o is 0, and every field holds its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchroniser |
| flash_data_i | input | 8 | Flash read data |
| flash_addr_o | output | 19 | Flash byte address |
| flash_cs_n_o | output | 1 | Flash chip select, active low, low for the whole byte slot |
| flash_rd_n_o | output | 1 | Flash read strobe, active low |
| tgt_retry_o | output | 1 | Retry request to the bus target while the header is being read |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| loaded_o | output | 1 | Set when a valid header was committed |
| dev_id_o | output | 16 | Device ID |
| class_code_o | output | 16 | Class code (sub-class and base class bytes) |
| subsys_vid_o | output | 16 | Subsystem vendor ID |
| subsys_id_o | output | 16 | Subsystem ID |
| phy_cfg_o | output | 32 | PHY configuration word |

## Verification
Every output is due in a clock that can be worked out from the point where rst_n is released:
- The first strobe falls in clock START_DLY+2.
- Each later strobe falls BYTE_CLK clocks after the one before it.
- Each strobe lasts SLOW_CLK or FAST_CLK clocks.
- done_o and the fall of tgt_retry_o arrive either a full slot after the last fall or one slow strobe length after an aborting read.

The bench counts falling clock edges from the release and records the clock of every strobe edge. It compares each recorded clock with the value computed from the header it placed in the flash model. It reads the loaded fields only once done_o has been seen. It sweeps every pass and fail combination of the three marker bytes together with both speed codes, and then runs corner-case payloads.

// File: rtl/fhl_pkg.sv
package fhl_pkg;

  typedef enum logic [1:0] {
    FHL_WAIT = 2'd0,
    FHL_READ = 2'd1,
    FHL_IDLE = 2'd2
  } fhl_state_e;

  localparam int FHL_HDR_BYTES    = 16;
  localparam int FHL_PAYLOAD      = 12;
  localparam int FHL_IDX_SIG_HI   = 0;
  localparam int FHL_IDX_SIG_LO   = 1;
  localparam int FHL_IDX_SPEED    = 2;
  localparam int FHL_IDX_CHECK    = 3;
  localparam int FHL_PAYLOAD_BASE = 4;

  localparam logic [7:0]  FHL_SIG_HI      = 8'hAA;
  localparam logic [7:0]  FHL_SIG_LO      = 8'h55;
  localparam logic [7:0]  FHL_CHECK       = 8'h55;
  localparam logic [7:0]  FHL_FAST_CODE   = 8'hAA;
  localparam logic [31:0] FHL_PHY_DEFAULT = 32'h000080F1;

endpackage

// File: rtl/fhl_seq.sv
module fhl_seq
  import fhl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int START_DLY = 33,
  parameter int SLOW_CLK  = 12,
  parameter int FAST_CLK  = 6,
  parameter int BYTE_CLK  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        flash_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              commit_o,
  output logic              smp_vld_o,
  output logic [3:0]        smp_idx_o,
  output logic [7:0]        smp_byte_o
);

  localparam int CNT_MAX = (START_DLY > BYTE_CLK) ? START_DLY : BYTE_CLK;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(START_DLY - 1);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(BYTE_CLK - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CLK - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CLK - 1);
  localparam logic [3:0]       IDX_LAST  = 4'(FHL_HDR_BYTES - 1);

  fhl_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       idx_q, idx_d;
  logic             fast_q, fast_d;
  logic             chk_q, chk_d;
  logic             done_q, done_d;
  logic             commit_q, commit_d;

  logic [CNT_W-1:0] strobe_last;
  logic             in_read;
  logic             samp;
  logic             slot_end;
  logic             sig_bad;

  assign strobe_last = fast_q ? FAST_LAST : SLOW_LAST;
  assign in_read     = (state_q == FHL_READ);
  assign samp        = in_read && (cnt_q == strobe_last);
  assign slot_end    = in_read && (cnt_q == SLOT_LAST);
  assign sig_bad     = samp &&
                       (((idx_q == 4'(FHL_IDX_SIG_HI)) && (flash_data_i != FHL_SIG_HI)) ||
                        ((idx_q == 4'(FHL_IDX_SIG_LO)) && (flash_data_i != FHL_SIG_LO)));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    fast_d   = fast_q;
    chk_d    = chk_q;
    done_d   = 1'b0;
    commit_d = 1'b0;
    case (state_q)
      FHL_WAIT: begin
        if (cnt_q == WAIT_LAST) begin
          state_d = FHL_READ;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FHL_READ: begin
        cnt_d = cnt_q + 1'b1;
        if (samp && (idx_q == 4'(FHL_IDX_SPEED))) begin
          fast_d = (flash_data_i == FHL_FAST_CODE);
        end
        if (samp && (idx_q == 4'(FHL_IDX_CHECK))) begin
          chk_d = (flash_data_i == FHL_CHECK);
        end
        if (sig_bad) begin
          state_d = FHL_IDLE;
          done_d  = 1'b1;
        end else if (slot_end) begin
          cnt_d = '0;
          if (idx_q == IDX_LAST) begin
            state_d  = FHL_IDLE;
            done_d   = 1'b1;
            commit_d = chk_q;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = FHL_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FHL_WAIT;
      cnt_q    <= '0;
      idx_q    <= '0;
      fast_q   <= 1'b0;
      chk_q    <= 1'b0;
      done_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      fast_q   <= fast_d;
      chk_q    <= chk_d;
      done_q   <= done_d;
      commit_q <= commit_d;
    end
  end

  assign addr_o     = {ADDR_W{1'b1}} - ADDR_W'(idx_q);
  assign cs_n_o     = !in_read;
  assign rd_n_o     = !(in_read && (cnt_q <= strobe_last));
  assign busy_o     = (state_q != FHL_IDLE);
  assign done_o     = done_q;
  assign commit_o   = commit_q;
  assign smp_vld_o  = samp;
  assign smp_idx_o  = idx_q;
  assign smp_byte_o = flash_data_i;

  // R9
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !cs_n_o);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |=> (rd_n_o || $stable(addr_o)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  retry_drop_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !busy_o);

  // R4
  commit_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> done_o);

endmodule

// File: rtl/fhl_capture.sv
module fhl_capture
  import fhl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_vld_i,
  input  logic [3:0]  smp_idx_i,
  input  logic [7:0]  smp_byte_i,
  input  logic        commit_i,
  output logic [15:0] dev_id_o,
  output logic [15:0] class_code_o,
  output logic [15:0] subsys_vid_o,
  output logic [15:0] subsys_id_o,
  output logic [31:0] phy_cfg_o,
  output logic        loaded_o
);

  logic [7:0] stage_w [FHL_PAYLOAD];

  for (genvar j = 0; j < FHL_PAYLOAD; j++) begin : g_stage
    logic       we;
    logic [7:0] byte_q;
    assign we = smp_vld_i && (smp_idx_i == 4'(FHL_PAYLOAD_BASE + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (we) begin
        byte_q <= smp_byte_i;
      end
    end
    assign stage_w[j] = byte_q;
  end

  logic [15:0] dev_q, class_q, svid_q, sid_q;
  logic [31:0] phy_q;
  logic        loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q    <= '0;
      class_q  <= '0;
      svid_q   <= '0;
      sid_q    <= '0;
      phy_q    <= FHL_PHY_DEFAULT;
      loaded_q <= 1'b0;
    end else if (commit_i) begin
      dev_q    <= {stage_w[1], stage_w[0]};
      class_q  <= {stage_w[3], stage_w[2]};
      svid_q   <= {stage_w[5], stage_w[4]};
      sid_q    <= {stage_w[7], stage_w[6]};
      phy_q    <= {stage_w[11], stage_w[10], stage_w[9], stage_w[8]};
      loaded_q <= 1'b1;
    end
  end

  assign dev_id_o     = dev_q;
  assign class_code_o = class_q;
  assign subsys_vid_o = svid_q;
  assign subsys_id_o  = sid_q;
  assign phy_cfg_o    = phy_q;
  assign loaded_o     = loaded_q;

  // R7
  phy_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_o |-> (phy_cfg_o == FHL_PHY_DEFAULT));

  // R6
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(phy_cfg_o) && $stable(dev_id_o)));

endmodule

// File: rtl/flash_hdr_loader.sv
module flash_hdr_loader
  import fhl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int START_DLY = 33,
  parameter int SLOW_CLK  = 12,
  parameter int FAST_CLK  = 6,
  parameter int BYTE_CLK  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        flash_data_i,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              flash_cs_n_o,
  output logic              flash_rd_n_o,
  output logic              tgt_retry_o,
  output logic              done_o,
  output logic              loaded_o,
  output logic [15:0]       dev_id_o,
  output logic [15:0]       class_code_o,
  output logic [15:0]       subsys_vid_o,
  output logic [15:0]       subsys_id_o,
  output logic [31:0]       phy_cfg_o
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic       commit;
  logic       smp_vld;
  logic [3:0] smp_idx;
  logic [7:0] smp_byte;

  fhl_seq #(
    .ADDR_W    (ADDR_W),
    .START_DLY (START_DLY),
    .SLOW_CLK  (SLOW_CLK),
    .FAST_CLK  (FAST_CLK),
    .BYTE_CLK  (BYTE_CLK)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .flash_data_i (flash_data_i),
    .addr_o       (flash_addr_o),
    .cs_n_o       (flash_cs_n_o),
    .rd_n_o       (flash_rd_n_o),
    .busy_o       (tgt_retry_o),
    .done_o       (done_o),
    .commit_o     (commit),
    .smp_vld_o    (smp_vld),
    .smp_idx_o    (smp_idx),
    .smp_byte_o   (smp_byte)
  );

  fhl_capture cap_i (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .smp_vld_i    (smp_vld),
    .smp_idx_i    (smp_idx),
    .smp_byte_i   (smp_byte),
    .commit_i     (commit),
    .dev_id_o     (dev_id_o),
    .class_code_o (class_code_o),
    .subsys_vid_o (subsys_vid_o),
    .subsys_id_o  (subsys_id_o),
    .phy_cfg_o    (phy_cfg_o),
    .loaded_o     (loaded_o)
  );

endmodule

// File: tb/flash_hdr_loader_tb.sv
module flash_hdr_loader_tb_top;

  localparam int D_DLY = 33;
  localparam int D_SLO = 12;
  localparam int D_FST = 6;
  localparam int D_BYT = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  flash_data;
  logic [18:0] flash_addr;
  logic        cs_n, rd_n, retry, done, loaded;
  logic [15:0] dev_id, class_code, svid, sid;
  logic [31:0] phy;
  logic [7:0]  hdr [16];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_hdr_loader dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .flash_data_i (flash_data),
    .flash_addr_o (flash_addr),
    .flash_cs_n_o (cs_n),
    .flash_rd_n_o (rd_n),
    .tgt_retry_o  (retry),
    .done_o       (done),
    .loaded_o     (loaded),
    .dev_id_o     (dev_id),
    .class_code_o (class_code),
    .subsys_vid_o (svid),
    .subsys_id_o  (sid),
    .phy_cfg_o    (phy)
  );

  always_comb begin
    if (!cs_n && !rd_n && (flash_addr >= 19'h7FFF0))
      flash_data = hdr[int'(19'h7FFFF - flash_addr)];
    else
      flash_data = 8'hFF;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_case();
    int  fall_at [16];
    int  width   [16];
    int  addr_at [16];
    int  nreads = 0;
    int  cyc = 0;
    int  busy_fall = -1;
    int  done_cyc = -1;
    int  done_cnt = 0;
    int  cs_bad = 0;
    int  late_reads = 0;
    bit  prev_rd = 1'b1;
    bit  sig_ok, valid, fast;
    int  exp_n, exp_done, exp_w;
    for (int i = 0; i < 16; i++) begin
      fall_at[i] = 0; width[i] = 0; addr_at[i] = 0;
    end
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rd_n && cs_n, "R10", "strobe/select in reset", {rd_n, cs_n}, 2'b11);
    check(retry == 1'b1 && done == 1'b0, "R10", "retry/done in reset", {retry, done}, 2'b10);
    check(phy == 32'h000080F1 && loaded == 1'b0 && dev_id == 16'h0, "R10", "fields in reset",
          phy, 32'h000080F1);
    rst_n = 1'b1;
    while (cyc < 700 && !(busy_fall >= 0 && cyc >= busy_fall + 10)) begin
      @(negedge clk);
      cyc++;
      if (!rd_n && cs_n) cs_bad++;
      if (!rd_n && prev_rd) begin
        if (busy_fall >= 0) late_reads++;
        if (nreads < 16) begin
          fall_at[nreads] = cyc;
          addr_at[nreads] = int'(flash_addr);
        end
        nreads++;
      end
      if (!rd_n && nreads >= 1 && nreads <= 16) width[nreads-1]++;
      prev_rd = rd_n;
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
      if (!retry && busy_fall < 0) busy_fall = cyc;
    end
    sig_ok = (hdr[0] == 8'hAA) && (hdr[1] == 8'h55);
    valid  = sig_ok && (hdr[3] == 8'h55);
    fast   = (hdr[2] == 8'hAA);
    exp_n  = (hdr[0] != 8'hAA) ? 1 : ((hdr[1] != 8'h55) ? 2 : 16);
    exp_done = D_DLY + 2 + (exp_n - 1) * D_BYT + (sig_ok ? D_BYT : D_SLO);
    // R1 start delay
    check(fall_at[0] == D_DLY + 2, "R1", "first strobe clock", fall_at[0], D_DLY + 2);
    // R3 / R2 read count
    check(nreads == exp_n, "R3", "number of reads", nreads, exp_n);
    for (int i = 0; i < exp_n && i < 16; i++) begin
      check(addr_at[i] == 19'h7FFFF - i, "R2", "read address", addr_at[i], 19'h7FFFF - i);
      if (i > 0)
        check(fall_at[i] - fall_at[i-1] == D_BYT, "R2", "slot spacing",
              fall_at[i] - fall_at[i-1], D_BYT);
      exp_w = (i >= 3 && fast) ? D_FST : D_SLO;
      check(width[i] == exp_w, "R5", "strobe width", width[i], exp_w);
    end
    // R8 completion
    check(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
    check(done_cyc == busy_fall, "R8", "done with retry fall", done_cyc, busy_fall);
    check(busy_fall == exp_done, "R8", "completion clock", busy_fall, exp_done);
    // R9
    check(cs_bad == 0, "R9", "strobe outside select", cs_bad, 0);
    check(late_reads == 0, "R9", "reads after done", late_reads, 0);
    if (valid) begin
      // R6 mapping
      check(loaded == 1'b1, "R6", "loaded flag", loaded, 1);
      check(dev_id == {hdr[5], hdr[4]}, "R6", "device id", dev_id, {hdr[5], hdr[4]});
      check(class_code == {hdr[7], hdr[6]}, "R6", "class code", class_code, {hdr[7], hdr[6]});
      check(svid == {hdr[9], hdr[8]}, "R6", "subsystem vendor", svid, {hdr[9], hdr[8]});
      check(sid == {hdr[11], hdr[10]}, "R6", "subsystem id", sid, {hdr[11], hdr[10]});
      check(phy == {hdr[15], hdr[14], hdr[13], hdr[12]}, "R6", "phy word", phy,
            {hdr[15], hdr[14], hdr[13], hdr[12]});
    end else begin
      // R7 defaults kept (R4 when only the check byte is wrong)
      check(loaded == 1'b0, sig_ok ? "R4" : "R7", "loaded flag", loaded, 0);
      check(phy == 32'h000080F1, "R7", "phy default", phy, 32'h000080F1);
      check({dev_id, class_code, svid, sid} == 64'h0, sig_ok ? "R4" : "R7",
            "id fields", {dev_id, class_code, svid, sid}, 0);
    end
  endtask

  task automatic fill(input int seed, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [7:0] b3);
    for (int k = 0; k < 16; k++) hdr[k] = 8'(k * 37 + seed * 11 + 3);
    hdr[0] = b0; hdr[1] = b1; hdr[2] = b2; hdr[3] = b3;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) hdr[k] = 8'h00;
    for (int s = 0; s < 16; s++) begin
      fill(s, s[0] ? 8'hA8 : 8'hAA, s[1] ? 8'h54 : 8'h55,
           s[2] ? 8'hAB : 8'hAA, s[3] ? 8'hD5 : 8'h55);
      run_case();
    end
    fill(20, 8'hAA, 8'h55, 8'h55, 8'h55);
    run_case();
    fill(21, 8'hAA, 8'h55, 8'h2A, 8'h55);
    run_case();
    fill(22, 8'hAA, 8'h55, 8'hAA, 8'h55);
    for (int k = 4; k < 16; k++) hdr[k] = 8'hFF;
    run_case();
    fill(23, 8'hAA, 8'h55, 8'hAA, 8'h55);
    for (int k = 4; k < 16; k++) hdr[k] = 8'h00;
    run_case();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule